// File: doc/BRIEF.md
# Self-Routing Load/Store Memory Crossbar

This block joins a set of load/store ports to a set of memory sections without any central switch controller. Each port presents one request per cycle, either a load or a store, with an address and a store-data word. Each crosspoint of the fabric looks at a small field of the travelling address, compares it with the number of its own section, and offers the request to that section's column when they agree. When several ports aim at one section in the same cycle, the lowest-numbered port takes the column and the others see a stall for that cycle.

Load data has its own return path, separate from the store-data path. Each section column keeps a short pipeline of issuing-port tags whose length equals the fixed read latency of the memory. When a tag reaches the end, the section's read data is steered back to the port that asked for it, with a valid strobe. Because stores never travel on the return path, a port can issue a store in the very cycle that one of its earlier loads comes back.

Top module: `lsx_fabric`

## Requirements
- R1: A granted request from port p that targets section s appears in the same cycle on section s as enable=1, with port p's address, write flag and store data.
- R2: The target section of a request is the address field of width clog2(NSEC) that starts at bit WOFF; with the defaults (WOFF=3, four sections) it is address bits [4:3].
- R3: Each section is driven by at most one port per cycle; among ports targeting the same section, the lowest-numbered one is granted.
- R4: A port with a valid request that is not granted has stall=1 and grant=0 in that cycle; a port without a valid request has grant=0 and stall=0.
- R5: A granted load returns exactly RDLAT rising edges after its issue cycle: ld_vld is 1 only on the issuing port, and ld_data equals the section's read data in that cycle.
- R6: A store never produces a load return, and a store issued in the cycle an earlier load returns is granted and routed while that return is delivered unchanged.
- R7: When every valid port targets a distinct section, all of them are granted in the same cycle (up to NPORT words per cycle).
- R8: Reset clears all pending load returns; during reset and for the RDLAT cycles after it, no ld_vld is raised for loads issued before reset.
- R9: A section with no granted request has enable=0, and a port with no load returning has ld_vld=0 and ld_data all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | NPORT | Request valid, bit p for port p |
| req_wr | input | NPORT | 1 = store, 0 = load, bit p for port p |
| req_addr | input | NPORT*AW | Word address per port, port p at [p*AW +: AW] |
| req_wdata | input | NPORT*DW | Store data per port |
| grant | output | NPORT | Request accepted this cycle |
| stall | output | NPORT | Request lost arbitration this cycle |
| ld_vld | output | NPORT | Load data returning to port |
| ld_data | output | NPORT*DW | Returned load data per port |
| sec_en | output | NSEC | Section access enable |
| sec_wr | output | NSEC | Section access is a store |
| sec_addr | output | NSEC*AW | Address delivered to each section |
| sec_wdata | output | NSEC*DW | Store data delivered to each section |
| sec_rdata | input | NSEC*DW | Section read data, valid RDLAT edges after a load enable |

## Verification
Grant, stall and all section-side outputs are combinational in the request, so they are due in the same cycle the request is driven; the bench drives inputs just after the falling edge and samples one nanosecond later. Load returns are due RDLAT rising edges after the issue cycle; the bench keeps its own expectation pipeline of that depth, advanced on the same rising edge as the design, and compares its last stage every cycle, so a return that arrives a cycle early or late, or on the wrong port, is reported. The memory model in the bench answers with data derived from section number and address, so a mis-steered return shows a wrong value.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

  localparam int unsigned ADDR_MAX = 64;
  localparam int unsigned SEL_MAX  = 8;

  // index width for n items, never below one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // section-select field: w bits of the address starting at bit off
  function automatic logic [SEL_MAX-1:0] sel_of(input logic [ADDR_MAX-1:0] a,
                                                input int unsigned off,
                                                input int unsigned w);
    logic [ADDR_MAX-1:0] sh;
    sh = (a >> off) & ((64'd1 << w) - 64'd1);
    return sh[SEL_MAX-1:0];
  endfunction

endpackage

// File: rtl/lsx_xpoint.sv
module lsx_xpoint #(
  parameter int unsigned AW     = 16,
  parameter int unsigned WOFF   = 3,
  parameter int unsigned SELW   = 2,
  parameter int unsigned SEC_ID = 0
) (
  input  logic          req_vld,
  input  logic [AW-1:0] req_addr,
  output logic          hit
);
  logic [lsx_pkg::SEL_MAX-1:0] field;

  // local decode: no global switch control reaches this point
  assign field = lsx_pkg::sel_of(lsx_pkg::ADDR_MAX'(req_addr), WOFF, SELW);
  assign hit   = req_vld && (field == lsx_pkg::SEL_MAX'(SEC_ID));
endmodule

// File: rtl/lsx_column.sv
module lsx_column #(
  parameter int unsigned NPORT = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 64,
  parameter int unsigned PIDW  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0]           hit,
  input  logic [NPORT-1:0]           wr,
  input  logic [NPORT-1:0][AW-1:0]   addr,
  input  logic [NPORT-1:0][DW-1:0]   wdata,
  output logic [NPORT-1:0]           win,
  output logic                       out_en,
  output logic                       out_wr,
  output logic [AW-1:0]              out_addr,
  output logic [DW-1:0]              out_wdata,
  output logic [PIDW-1:0]            out_pid
);
  logic found;

  // fixed priority: lowest port index takes the column
  always_comb begin
    win     = '0;
    found   = 1'b0;
    out_pid = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (hit[p] && !found) begin
        win[p]  = 1'b1;
        found   = 1'b1;
        out_pid = PIDW'(p);
      end
    end
  end

  // column line: only the enabled crosspoint drives it
  always_comb begin
    out_wr    = 1'b0;
    out_addr  = '0;
    out_wdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (win[p]) begin
        out_wr    = wr[p];
        out_addr  = addr[p];
        out_wdata = wdata[p];
      end
    end
  end

  assign out_en = found;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win)); // R3
  AST_ANY_HIT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |-> (out_en && $onehot(win))); // R3
  AST_LOW_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> win[0]); // R3
endmodule

// File: rtl/lsx_rettag.sv
module lsx_rettag #(
  parameter int unsigned RDLAT = 3,
  parameter int unsigned PIDW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [PIDW-1:0] pid,
  output logic            tail_vld,
  output logic [PIDW-1:0] tail_pid
);
  logic [RDLAT-1:0]           tv;
  logic [RDLAT-1:0][PIDW-1:0] tid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv  <= '0;
      tid <= '0;
    end else begin
      tv[0]  <= issue;
      tid[0] <= pid;
      for (int i = 1; i < RDLAT; i++) begin
        tv[i]  <= tv[i-1];
        tid[i] <= tid[i-1];
      end
    end
  end

  assign tail_vld = tv[RDLAT-1];
  assign tail_pid = tid[RDLAT-1];

  AST_NO_TAG_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !tv[0]); // R6
  AST_TAG_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (tv[0] && tid[0] == $past(pid))); // R5
endmodule

// File: rtl/lsx_fabric.sv
module lsx_fabric #(
  parameter int unsigned NPORT = 4,
  parameter int unsigned NSEC  = 4,
  parameter int unsigned DW    = 64,
  parameter int unsigned AW    = 16,
  parameter int unsigned WOFF  = 3,
  parameter int unsigned RDLAT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      req_vld,
  input  logic [NPORT-1:0]      req_wr,
  input  logic [NPORT*AW-1:0]   req_addr,
  input  logic [NPORT*DW-1:0]   req_wdata,
  output logic [NPORT-1:0]      grant,
  output logic [NPORT-1:0]      stall,
  output logic [NPORT-1:0]      ld_vld,
  output logic [NPORT*DW-1:0]   ld_data,
  output logic [NSEC-1:0]       sec_en,
  output logic [NSEC-1:0]       sec_wr,
  output logic [NSEC*AW-1:0]    sec_addr,
  output logic [NSEC*DW-1:0]    sec_wdata,
  input  logic [NSEC*DW-1:0]    sec_rdata
);
  localparam int unsigned SELW = lsx_pkg::idx_w(NSEC);
  localparam int unsigned PIDW = lsx_pkg::idx_w(NPORT);

  logic [NPORT-1:0][AW-1:0]  p_addr;
  logic [NPORT-1:0][DW-1:0]  p_wdata;
  logic [NPORT-1:0][DW-1:0]  p_ld;
  logic [NSEC-1:0][AW-1:0]   s_addr;
  logic [NSEC-1:0][DW-1:0]   s_wdata;
  logic [NSEC-1:0][DW-1:0]   s_rdata;
  logic [NSEC-1:0][NPORT-1:0] hit_sp;
  logic [NSEC-1:0][NPORT-1:0] win_sp;
  logic [NSEC-1:0][PIDW-1:0]  col_pid;
  logic [NSEC-1:0]            load_issue;
  logic [NSEC-1:0]            tail_vld;
  logic [NSEC-1:0][PIDW-1:0]  tail_pid;
  logic [NPORT-1:0][NSEC-1:0] ret_ps;

  assign p_addr    = req_addr;
  assign p_wdata   = req_wdata;
  assign s_rdata   = sec_rdata;
  assign sec_addr  = s_addr;
  assign sec_wdata = s_wdata;
  assign ld_data   = p_ld;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    for (genvar p = 0; p < NPORT; p++) begin : g_xp
      lsx_xpoint #(.AW(AW), .WOFF(WOFF), .SELW(SELW), .SEC_ID(s)) u_xp (
        .req_vld (req_vld[p]),
        .req_addr(p_addr[p]),
        .hit     (hit_sp[s][p])
      );
    end

    lsx_column #(.NPORT(NPORT), .AW(AW), .DW(DW), .PIDW(PIDW)) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit_sp[s]),
      .wr       (req_wr),
      .addr     (p_addr),
      .wdata    (p_wdata),
      .win      (win_sp[s]),
      .out_en   (sec_en[s]),
      .out_wr   (sec_wr[s]),
      .out_addr (s_addr[s]),
      .out_wdata(s_wdata[s]),
      .out_pid  (col_pid[s])
    );

    assign load_issue[s] = sec_en[s] && !sec_wr[s];

    lsx_rettag #(.RDLAT(RDLAT), .PIDW(PIDW)) u_ret (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue   (load_issue[s]),
      .pid     (col_pid[s]),
      .tail_vld(tail_vld[s]),
      .tail_pid(tail_pid[s])
    );

    AST_SEC_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      sec_en[s] |-> (lsx_pkg::sel_of(lsx_pkg::ADDR_MAX'(s_addr[s]), WOFF, SELW)
                     == lsx_pkg::SEL_MAX'(s))); // R2
  end

  // port side: grant gathering and load-return steering
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      grant[p] = 1'b0;
      for (int s = 0; s < NSEC; s++) begin
        grant[p]     = grant[p] | win_sp[s][p];
        ret_ps[p][s] = tail_vld[s] && (tail_pid[s] == PIDW'(p));
      end
      stall[p] = req_vld[p] && !grant[p];
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      ld_vld[p] = |ret_ps[p];
      p_ld[p]   = '0;
      for (int s = 0; s < NSEC; s++) begin
        if (ret_ps[p][s]) p_ld[p] = p_ld[p] | s_rdata[s];
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    AST_GRANT_OR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld[p] |-> (grant[p] ^ stall[p])); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld[p] |-> (!grant[p] && !stall[p])); // R4
    AST_ONE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ret_ps[p])); // R5
  end
endmodule

// File: tb/test_lsx_fabric.sv
module test_lsx_fabric;
  localparam int NPORT = 4;
  localparam int NSEC  = 4;
  localparam int DW    = 64;
  localparam int AW    = 16;
  localparam int WOFF  = 3;
  localparam int RDLAT = 3;
  localparam int NVEC  = 8;

  // vector: {vld[3:0], wr[3:0], addr3, addr2, addr1, addr0}
  localparam logic [71:0] VEC [NVEC] = '{
    {4'hF, 4'h0, 16'h0418, 16'h0310, 16'h0208, 16'h0100},  // R7 distinct sections
    {4'hF, 4'h5, 16'h1100, 16'h1208, 16'h1310, 16'h1418},  // mixed stores/loads
    {4'h7, 4'h0, 16'h0000, 16'h2210, 16'h2110, 16'h2010},  // R3 three on sec2
    {4'hA, 4'h2, 16'h3308, 16'h0000, 16'h3108, 16'h0000},  // R6 store during return
    {4'hC, 4'h0, 16'h4400, 16'h4500, 16'h0000, 16'h0000},  // R3 p2 beats p3
    {4'h0, 4'h0, 64'h0},                                   // idle
    {4'h9, 4'h0, 16'h6618, 16'h0000, 16'h0000, 16'h6018},  // R3 p0 beats p3
    {4'hF, 4'h0, 16'h7708, 16'h7608, 16'h7508, 16'h7408}   // all on sec1
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NPORT-1:0]     req_vld = '0;
  logic [NPORT-1:0]     req_wr = '0;
  logic [NPORT*AW-1:0]  req_addr = '0;
  logic [NPORT*DW-1:0]  req_wdata = '0;
  logic [NPORT-1:0]     grant, stall, ld_vld;
  logic [NPORT*DW-1:0]  ld_data;
  logic [NSEC-1:0]      sec_en, sec_wr;
  logic [NSEC*AW-1:0]   sec_addr;
  logic [NSEC*DW-1:0]   sec_wdata;
  logic [NSEC*DW-1:0]   sec_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsx_fabric #(.NPORT(NPORT), .NSEC(NSEC), .DW(DW), .AW(AW), .WOFF(WOFF),
               .RDLAT(RDLAT)) i_lsx_fabric (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant), .stall(stall),
    .ld_vld(ld_vld), .ld_data(ld_data), .sec_en(sec_en), .sec_wr(sec_wr),
    .sec_addr(sec_addr), .sec_wdata(sec_wdata), .sec_rdata(sec_rdata)
  );

  function automatic logic [DW-1:0] pat(input int s, input logic [AW-1:0] a);
    return {8'(s), 8'hA5, 32'h0, a};
  endfunction

  // memory model: read data appears RDLAT edges after a load enable
  logic          mv [RDLAT][NSEC];
  logic [AW-1:0] ma [RDLAT][NSEC];
  always @(posedge clk or negedge rst_n) begin
    for (int s = 0; s < NSEC; s++) begin
      for (int i = RDLAT - 1; i >= 0; i--) begin
        if (!rst_n) begin
          mv[i][s] <= 1'b0; ma[i][s] <= '0;
        end else if (i == 0) begin
          mv[0][s] <= sec_en[s] && !sec_wr[s];
          ma[0][s] <= sec_addr[s*AW +: AW];
        end else begin
          mv[i][s] <= mv[i-1][s]; ma[i][s] <= ma[i-1][s];
        end
      end
    end
  end
  always_comb begin
    for (int s = 0; s < NSEC; s++)
      sec_rdata[s*DW +: DW] = mv[RDLAT-1][s] ? pat(s, ma[RDLAT-1][s])
                                             : (64'hDEAD_0000_0000_0000 | 64'(s));
  end

  // expected load returns, one stage per edge
  logic          cur_v [NPORT];
  logic [DW-1:0] cur_d [NPORT];
  logic          ev [RDLAT][NPORT];
  logic [DW-1:0] ed [RDLAT][NPORT];
  initial for (int p = 0; p < NPORT; p++) begin cur_v[p] = 1'b0; cur_d[p] = '0; end
  always @(posedge clk or negedge rst_n) begin
    for (int p = 0; p < NPORT; p++) begin
      for (int i = RDLAT - 1; i >= 0; i--) begin
        if (!rst_n) begin
          ev[i][p] <= 1'b0; ed[i][p] <= '0;
        end else if (i == 0) begin
          ev[0][p] <= cur_v[p]; ed[0][p] <= cur_d[p];
        end else begin
          ev[i][p] <= ev[i-1][p]; ed[i][p] <= ed[i-1][p];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_returns();
    for (int p = 0; p < NPORT; p++) begin
      chk(ld_vld[p] == ev[RDLAT-1][p], "R5/R8 ld_vld", 64'(ld_vld[p]),
          64'(ev[RDLAT-1][p]));
      chk(ld_data[p*DW +: DW] == (ev[RDLAT-1][p] ? ed[RDLAT-1][p] : '0),
          "R5/R9 ld_data", ld_data[p*DW +: DW],
          ev[RDLAT-1][p] ? ed[RDLAT-1][p] : '0);
    end
  endtask

  // one cycle: drive after falling edge, check 1 ns later
  task automatic step(input logic [3:0] v, input logic [3:0] w,
                      input logic [63:0] a, input int k);
    int  es [NPORT];
    bit  eg [NPORT];
    @(negedge clk);
    req_vld = v;
    req_wr  = w;
    req_addr = a;
    for (int p = 0; p < NPORT; p++)
      req_wdata[p*DW +: DW] = 64'hD000_0000_0000_0000 | 64'(k << 8) | 64'(p);
    for (int p = 0; p < NPORT; p++) begin
      es[p] = int'(a[p*AW + WOFF +: 2]);  // R2 bits [4:3]
      eg[p] = v[p];
      for (int q = 0; q < p; q++)
        if (v[q] && es[q] == es[p]) eg[p] = 1'b0;
      cur_v[p] = eg[p] && !w[p];
      cur_d[p] = pat(es[p], a[p*AW +: AW]);
    end
    #1;
    for (int p = 0; p < NPORT; p++) begin
      chk(grant[p] == eg[p], "R3/R7 grant", 64'(grant[p]), 64'(eg[p]));
      chk(stall[p] == (v[p] && !eg[p]), "R4 stall", 64'(stall[p]),
          64'(v[p] && !eg[p]));
    end
    for (int s = 0; s < NSEC; s++) begin
      int g;
      g = -1;
      for (int p = NPORT - 1; p >= 0; p--) if (eg[p] && es[p] == s) g = p;
      chk(sec_en[s] == (g >= 0), "R1/R9 sec_en", 64'(sec_en[s]), 64'(g >= 0));
      if (g >= 0) begin
        chk(sec_addr[s*AW +: AW] == a[g*AW +: AW], "R1/R2 sec_addr",
            64'(sec_addr[s*AW +: AW]), 64'(a[g*AW +: AW]));
        chk(sec_wr[s] == w[g], "R1 sec_wr", 64'(sec_wr[s]), 64'(w[g]));
        if (w[g])
          chk(sec_wdata[s*DW +: DW] == req_wdata[g*DW +: DW], "R1/R6 sec_wdata",
              sec_wdata[s*DW +: DW], req_wdata[g*DW +: DW]);
      end
    end
    check_returns();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(sec_en == '0, "R8 reset sec_en", 64'(sec_en), 64'h0);
    chk(ld_vld == '0, "R8 reset ld_vld", 64'(ld_vld), 64'h0);
    chk(grant == '0, "R8 reset grant", 64'(grant), 64'h0);
    rst_n = 1'b1;

    // table walk
    for (int k = 0; k < NVEC; k++)
      step(VEC[k][71:68], VEC[k][67:64], VEC[k][63:0], k);
    for (int k = 0; k < RDLAT; k++) step(4'h0, 4'h0, 64'h0, 100 + k);

    // R6 directed: port0 load, store on same port in its return cycle
    step(4'h1, 4'h0, {48'h0, 16'h8108}, 200);
    for (int k = 1; k < RDLAT; k++) step(4'h0, 4'h0, 64'h0, 200 + k);
    step(4'h1, 4'h1, {48'h0, 16'h8210}, 210);
    step(4'h0, 4'h0, 64'h0, 211);

    // R8 directed: reset with a load in flight
    step(4'h2, 4'h0, {32'h0, 16'h5510, 16'h0}, 300);
    step(4'h0, 4'h0, 64'h0, 301);
    @(negedge clk);
    rst_n = 1'b0;
    for (int p = 0; p < NPORT; p++) cur_v[p] = 1'b0;
    #1;
    chk(ld_vld == '0, "R8 in-reset ld_vld", 64'(ld_vld), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k <= RDLAT; k++) begin
      step(4'h0, 4'h0, 64'h0, 310 + k);
      chk(ld_vld == '0, "R8 post-reset ld_vld", 64'(ld_vld), 64'h0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule